// File: doc/BRIEF.md
# Variable-length instruction fetch decoder

This block is the front end of a small 8-bit processor whose whole address space is 256 bytes. It walks a program counter through a synchronous byte-wide memory, one read at a time. It classifies each opcode to learn whether the instruction occupies one, two or three bytes, and gathers the operand bytes. It then presents a decoded bundle to the executor: opcode, operand kind, register indices, immediate or target byte, start address and the address of the following instruction.

The executor takes a bundle with a valid/ready handshake. It steers control flow by driving a redirect address, which discards whatever is being gathered. An opcode outside the instruction table stops the block and raises a sticky error flag that only reset clears.

Top module: `ifd_fetch_decoder`

## Requirements
- R1: After reset the block issues its first read at address 0x00 at once, with `bnd_valid` and `illegal` low.
- R2: Each instruction byte costs one read. Read data is taken in the cycle after `mem_rd` is high, and `mem_rd` is never high in two consecutive cycles.
- R3: Opcodes 0x00, 0x01 and 0x21 are one byte long. Opcodes 0x02, 0x03, 0x06, 0x0A, 0x0C, 0x1B, 0x1D and 0x1F are three bytes long. Every other opcode from 0x00 to 0x27 is two bytes long. `bnd_len` gives the length as 1, 2 or 3.
- R4: `bnd_kind` encodes the operand kind: 0 no operand (the one-byte opcodes), 1 register plus byte (the three-byte opcodes), 2 jump target (0x16, 0x17, 0x18, 0x20), 4 register pair (0x04, 0x05, 0x09, 0x0B, 0x0F, 0x10, 0x11, 0x13, 0x1A, 0x1C, 0x1E, 0x27), 3 single register (all other legal opcodes).
- R5: For kind 1, `bnd_rd` is bits 3:0 of the second byte and `bnd_imm` is the third byte. `bnd_rs` is 0.
- R6: For kind 2, `bnd_imm` is the second byte and `bnd_rd` and `bnd_rs` are 0. For kind 0, all three fields are 0.
- R7: For kind 3, `bnd_rd` is bits 3:0 of the second byte, and `bnd_rs` and `bnd_imm` are 0.
- R8: For kind 4, `bnd_rd` is bits 7:4 and `bnd_rs` is bits 3:0 of the second byte. `bnd_imm` is 0.
- R9: `bnd_pc` is the address of the opcode. `bnd_next_pc` is that address plus the length, modulo 256. Operand reads wrap from 0xFF to 0x00.
- R10: A bundle that is not taken holds all its fields steady. In the cycle after a handshake, the block reads at `bnd_next_pc`.
- R11: An opcode of 0x28 or above sets `illegal`. From then until reset there are no reads, no bundles, and redirects have no effect.
- R12: While `redir_valid` is high, `bnd_valid` is low and no read is issued. In the next cycle, the block reads at `redir_addr` and any partly gathered or waiting instruction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd | output | 1 | Read strobe to the program memory |
| mem_addr | output | 8 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| redir_valid | input | 1 | Redirect request from the executor |
| redir_addr | input | 8 | New fetch address |
| bnd_valid | output | 1 | Decoded bundle available |
| bnd_ready | input | 1 | Executor takes the bundle |
| bnd_pc | output | 8 | Address of the opcode |
| bnd_next_pc | output | 8 | Address of the following instruction |
| bnd_opcode | output | 8 | Opcode byte |
| bnd_len | output | 2 | Instruction length in bytes |
| bnd_kind | output | 3 | Operand kind code |
| bnd_rd | output | 4 | Destination register index |
| bnd_rs | output | 4 | Source register index |
| bnd_imm | output | 8 | Immediate value or target address |
| illegal | output | 1 | Sticky illegal-opcode flag |

## Verification
A redirect can land in the same cycle as a bundle handshake, or in the middle of operand gathering while a read is outstanding. The bench raises `bnd_ready` and `redir_valid` on the same edge while a bundle is waiting. It expects `bnd_valid` to drop in that cycle, and it expects the next bundle to describe the redirect target rather than the instruction after the dropped one. It also redirects two cycles into a fetch and one byte into an operand fetch. It then checks that the stale read data is ignored and that the next read goes to the new address.

// File: rtl/ifd_pkg.sv
// Package: shared widths and enumerations for the fetch decoder.
// Assumes byte-wide instructions and 16 architectural registers.
package ifd_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_IDX_W = 4;
    localparam int LEN_W     = 2;

    // Operand kind code presented to the executor
    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_REGIMM = 3'd1,
        K_TARGET = 3'd2,
        K_ONEREG = 3'd3,
        K_TWOREG = 3'd4
    } op_kind_e;

    // Fetch sequencer states
    typedef enum logic [2:0] {
        S_OP,
        S_OPA,
        S_OPB,
        S_OUT,
        S_ERR
    } fetch_st_e;
endpackage

// File: rtl/ifd_opclass.sv
// Module: opcode classifier. It maps an opcode byte to its length, its
// operand kind and a legal flag. It is purely combinational.
// Assumes the opcode space 0x00..0x27 is fully populated.
module ifd_opclass
    import ifd_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_kind_e          kind,
    output logic [LEN_W-1:0]  len,
    output logic              legal
);
    // Table lookup: each opcode group sets its length and kind
    always_comb begin
        legal = 1'b1;
        kind  = K_NONE;
        len   = 2'd1;
        case (opcode)
            8'h00, 8'h01, 8'h21: begin
                kind = K_NONE;
                len  = 2'd1;
            end
            8'h02, 8'h03, 8'h06, 8'h0A, 8'h0C, 8'h1B, 8'h1D, 8'h1F: begin
                kind = K_REGIMM;
                len  = 2'd3;
            end
            8'h16, 8'h17, 8'h18, 8'h20: begin
                kind = K_TARGET;
                len  = 2'd2;
            end
            8'h04, 8'h05, 8'h09, 8'h0B, 8'h0F, 8'h10,
            8'h11, 8'h13, 8'h1A, 8'h1C, 8'h1E, 8'h27: begin
                kind = K_TWOREG;
                len  = 2'd2;
            end
            8'h07, 8'h08, 8'h0D, 8'h0E, 8'h12, 8'h14, 8'h15,
            8'h19, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26: begin
                kind = K_ONEREG;
                len  = 2'd2;
            end
            default: begin
                legal = 1'b0;
                kind  = K_NONE;
                len   = 2'd1;
            end
        endcase
    end
endmodule

// File: rtl/ifd_fetch_fsm.sv
// Module: fetch sequencer. It issues one read per byte, waits a cycle for
// the synchronous memory, and captures the opcode and up to two operand
// bytes. It holds the finished instruction until the executor takes it.
// Assumes memory data follows the read strobe by exactly one cycle.
// A redirect outranks everything except the error state.
module ifd_fetch_fsm
    import ifd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              out_ready,
    input  op_kind_e          cls_kind,
    input  logic [LEN_W-1:0]  cls_len,
    input  logic              cls_legal,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] start_pc,
    output logic [BYTE_W-1:0] op_byte,
    output logic [BYTE_W-1:0] opa_byte,
    output logic [BYTE_W-1:0] opb_byte,
    output logic [LEN_W-1:0]  ins_len,
    output op_kind_e          ins_kind,
    output logic              err
);
    localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    fetch_st_e          st_q;
    logic               wait_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [ADDR_W-1:0]  start_q;
    logic [BYTE_W-1:0]  op_q, opa_q, opb_q;
    logic [LEN_W-1:0]   len_q;
    op_kind_e           kind_q;
    logic               collecting;
    logic               byte_in;

    // A gathering state is one that still needs bytes from memory
    assign collecting = (st_q == S_OP) || (st_q == S_OPA) || (st_q == S_OPB);
    assign byte_in    = collecting && wait_q;

    // Sequencer state, fetch pointer and captured bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_OP;
            wait_q  <= 1'b0;
            ptr_q   <= PC_INIT;
            start_q <= PC_INIT;
            op_q    <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            len_q   <= 2'd1;
            kind_q  <= K_NONE;
        end else if (redir_valid && st_q != S_ERR) begin
            st_q   <= S_OP;
            wait_q <= 1'b0;
            ptr_q  <= redir_addr;
        end else if (collecting && !wait_q) begin
            wait_q <= 1'b1;
            if (st_q == S_OP) begin
                start_q <= ptr_q;
            end
        end else if (byte_in) begin
            wait_q <= 1'b0;
            ptr_q  <= ptr_q + PC_STEP;
            case (st_q)
                S_OP: begin
                    op_q   <= mem_rdata;
                    opa_q  <= '0;
                    opb_q  <= '0;
                    kind_q <= cls_kind;
                    len_q  <= cls_len;
                    if (!cls_legal) begin
                        st_q <= S_ERR;
                    end else if (cls_len == 2'd1) begin
                        st_q <= S_OUT;
                    end else begin
                        st_q <= S_OPA;
                    end
                end
                S_OPA: begin
                    opa_q <= mem_rdata;
                    st_q  <= (len_q == 2'd3) ? S_OPB : S_OUT;
                end
                default: begin
                    opb_q <= mem_rdata;
                    st_q  <= S_OUT;
                end
            endcase
        end else if (st_q == S_OUT && out_ready) begin
            st_q <= S_OP;
        end
    end

    assign mem_rd    = collecting && !wait_q && !redir_valid;
    assign mem_addr  = ptr_q;
    assign out_valid = (st_q == S_OUT) && !redir_valid;
    assign start_pc  = start_q;
    assign op_byte   = op_q;
    assign opa_byte  = opa_q;
    assign opb_byte  = opb_q;
    assign ins_len   = len_q;
    assign ins_kind  = kind_q;
    assign err       = (st_q == S_ERR);
endmodule

// File: rtl/ifd_operand_pack.sv
// Module: operand packer. It splits the captured operand bytes into
// register indices and an immediate byte according to the operand kind,
// and forms the address of the following instruction.
// Assumes unused operand bytes were cleared when the opcode was captured.
module ifd_operand_pack
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  op_kind_e             kind,
    input  logic [LEN_W-1:0]     len,
    input  logic [ADDR_W-1:0]    start_pc,
    input  logic [BYTE_W-1:0]    opa_byte,
    input  logic [BYTE_W-1:0]    opb_byte,
    output logic [REG_IDX_W-1:0] rd,
    output logic [REG_IDX_W-1:0] rs,
    output logic [BYTE_W-1:0]    imm,
    output logic [ADDR_W-1:0]    next_pc
);
    localparam int HI_LSB = BYTE_W - REG_IDX_W;

    // Field split per operand kind
    always_comb begin
        rd  = '0;
        rs  = '0;
        imm = '0;
        case (kind)
            K_REGIMM: begin
                rd  = opa_byte[REG_IDX_W-1:0];
                imm = opb_byte;
            end
            K_TARGET: imm = opa_byte;
            K_ONEREG: rd  = opa_byte[REG_IDX_W-1:0];
            K_TWOREG: begin
                rd = opa_byte[BYTE_W-1:HI_LSB];
                rs = opa_byte[REG_IDX_W-1:0];
            end
            default: ;
        endcase
    end

    // Wrapping advance by the instruction length
    assign next_pc = start_pc + ADDR_W'(len);
endmodule

// File: rtl/ifd_fetch_decoder.sv
// Module: top of the variable-length fetch decoder. It joins the
// classifier, the sequencer and the operand packer.
// Assumes a 256-byte space (ADDR_W = 8) and one-cycle read latency.
module ifd_fetch_decoder
    import ifd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RESET_PC = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [BYTE_W-1:0]    mem_rdata,
    input  logic                 redir_valid,
    input  logic [ADDR_W-1:0]    redir_addr,
    output logic                 bnd_valid,
    input  logic                 bnd_ready,
    output logic [ADDR_W-1:0]    bnd_pc,
    output logic [ADDR_W-1:0]    bnd_next_pc,
    output logic [BYTE_W-1:0]    bnd_opcode,
    output logic [LEN_W-1:0]     bnd_len,
    output logic [2:0]           bnd_kind,
    output logic [REG_IDX_W-1:0] bnd_rd,
    output logic [REG_IDX_W-1:0] bnd_rs,
    output logic [BYTE_W-1:0]    bnd_imm,
    output logic                 illegal
);
    op_kind_e          cls_kind, ins_kind;
    logic [LEN_W-1:0]  cls_len, ins_len;
    logic              cls_legal;
    logic [BYTE_W-1:0] opa_byte, opb_byte;

    ifd_opclass u_cls (
        .opcode (mem_rdata),
        .kind   (cls_kind),
        .len    (cls_len),
        .legal  (cls_legal)
    );

    ifd_fetch_fsm #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .mem_rdata   (mem_rdata),
        .out_ready   (bnd_ready),
        .cls_kind    (cls_kind),
        .cls_len     (cls_len),
        .cls_legal   (cls_legal),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .out_valid   (bnd_valid),
        .start_pc    (bnd_pc),
        .op_byte     (bnd_opcode),
        .opa_byte    (opa_byte),
        .opb_byte    (opb_byte),
        .ins_len     (ins_len),
        .ins_kind    (ins_kind),
        .err         (illegal)
    );

    ifd_operand_pack #(.ADDR_W(ADDR_W)) u_pack (
        .kind     (ins_kind),
        .len      (ins_len),
        .start_pc (bnd_pc),
        .opa_byte (opa_byte),
        .opb_byte (opb_byte),
        .rd       (bnd_rd),
        .rs       (bnd_rs),
        .imm      (bnd_imm),
        .next_pc  (bnd_next_pc)
    );

    assign bnd_len  = ins_len;
    assign bnd_kind = ins_kind;
endmodule

// File: rtl/ifd_checker.sv
// Module: protocol checker for the fetch decoder, bound to the top.
// It observes ports only.
module ifd_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic              bnd_valid,
    input logic              bnd_ready,
    input logic [ADDR_W-1:0] bnd_pc,
    input logic [ADDR_W-1:0] bnd_next_pc,
    input logic [7:0]        bnd_opcode,
    input logic [1:0]        bnd_len,
    input logic [2:0]        bnd_kind,
    input logic [3:0]        bnd_rs,
    input logic [7:0]        bnd_imm,
    input logic              illegal
);
    p_read_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> (bnd_len != 2'd0));

    p_rs_only_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && bnd_kind != 3'd4) |-> (bnd_rs == 4'd0));

    p_next_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && bnd_ready) |=>
            (redir_valid || (mem_rd && mem_addr == $past(bnd_next_pc))));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !bnd_ready) |=>
            (redir_valid || (bnd_valid && $stable(bnd_opcode) &&
             $stable(bnd_imm) && $stable(bnd_pc))));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_rd && !bnd_valid));

    p_redir_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (!bnd_valid && !mem_rd));

    p_redir_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !illegal) |=>
            (redir_valid || (mem_rd && mem_addr == $past(redir_addr))));
endmodule

bind ifd_fetch_decoder ifd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .bnd_valid   (bnd_valid),
    .bnd_ready   (bnd_ready),
    .bnd_pc      (bnd_pc),
    .bnd_next_pc (bnd_next_pc),
    .bnd_opcode  (bnd_opcode),
    .bnd_len     (bnd_len),
    .bnd_kind    (bnd_kind),
    .bnd_rs      (bnd_rs),
    .bnd_imm     (bnd_imm),
    .illegal     (illegal)
);

// File: tb/ifd_fetch_decoder_tb.sv
module ifd_fetch_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_rd;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;
    logic       redir_valid = 1'b0;
    logic [7:0] redir_addr = 8'h00;
    logic       bnd_valid;
    logic       bnd_ready = 1'b0;
    logic [7:0] bnd_pc, bnd_next_pc, bnd_opcode, bnd_imm;
    logic [1:0] bnd_len;
    logic [2:0] bnd_kind;
    logic [3:0] bnd_rd, bnd_rs;
    logic       illegal;

    logic [7:0] mem [256];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ifd_fetch_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .bnd_valid(bnd_valid), .bnd_ready(bnd_ready), .bnd_pc(bnd_pc),
        .bnd_next_pc(bnd_next_pc), .bnd_opcode(bnd_opcode), .bnd_len(bnd_len),
        .bnd_kind(bnd_kind), .bnd_rd(bnd_rd), .bnd_rs(bnd_rs), .bnd_imm(bnd_imm),
        .illegal(illegal)
    );

    // Synchronous memory model
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    function automatic int ref_len(input logic [7:0] op);
        case (op)
            8'h00, 8'h01, 8'h21: return 1;
            8'h02, 8'h03, 8'h06, 8'h0A, 8'h0C, 8'h1B, 8'h1D, 8'h1F: return 3;
            default: return (op < 8'h28) ? 2 : 0;
        endcase
    endfunction

    function automatic int ref_kind(input logic [7:0] op);
        case (op)
            8'h00, 8'h01, 8'h21: return 0;
            8'h02, 8'h03, 8'h06, 8'h0A, 8'h0C, 8'h1B, 8'h1D, 8'h1F: return 1;
            8'h16, 8'h17, 8'h18, 8'h20: return 2;
            8'h04, 8'h05, 8'h09, 8'h0B, 8'h0F, 8'h10,
            8'h11, 8'h13, 8'h1A, 8'h1C, 8'h1E, 8'h27: return 4;
            default: return 3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_instr(input logic [7:0] pc, input logic [7:0] op,
                             input logic [7:0] a, input logic [7:0] b);
        mem[pc] = op;
        mem[8'(pc + 8'd1)] = a;
        if (ref_len(op) == 3) mem[8'(pc + 8'd2)] = b;
    endtask

    // Wait for a bundle and compare it with the bench decode of memory
    task automatic wait_check(input logic [7:0] pc);
        int k;
        logic [7:0] op, a, b;
        int kd, ln;
        k = 0;
        while (!bnd_valid && k < 60) begin
            @(negedge clk);
            k++;
        end
        check("R10 bundle arrives", int'(bnd_valid), 1);
        op = mem[pc];
        a = mem[8'(pc + 8'd1)];
        b = mem[8'(pc + 8'd2)];
        kd = ref_kind(op);
        ln = ref_len(op);
        check("R9 start address", int'(bnd_pc), int'(pc));
        check("R3 length", int'(bnd_len), ln);
        check("R4 kind", int'(bnd_kind), kd);
        check("R3 opcode", int'(bnd_opcode), int'(op));
        check("R9 next address", int'(bnd_next_pc), int'(8'(pc + 8'(ln))));
        case (kd)
            1: begin
                check("R5 rd", int'(bnd_rd), int'(a[3:0]));
                check("R5 imm", int'(bnd_imm), int'(b));
                check("R5 rs", int'(bnd_rs), 0);
            end
            2: begin
                check("R6 target", int'(bnd_imm), int'(a));
                check("R6 rd", int'(bnd_rd), 0);
            end
            3: begin
                check("R7 rd", int'(bnd_rd), int'(a[3:0]));
                check("R7 imm", int'(bnd_imm), 0);
            end
            4: begin
                check("R8 rd", int'(bnd_rd), int'(a[7:4]));
                check("R8 rs", int'(bnd_rs), int'(a[3:0]));
                check("R8 imm", int'(bnd_imm), 0);
            end
            default: check("R6 fields empty", int'(bnd_imm) + int'(bnd_rd), 0);
        endcase
    endtask

    // Hold the bundle for some cycles, then take it; check the next read
    task automatic accept(input int stall, input logic [7:0] nxt);
        logic [7:0] op0;
        op0 = bnd_opcode;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R10 held", int'(bnd_valid && bnd_opcode == op0), 1);
            check("R2 no read while held", int'(mem_rd), 0);
        end
        bnd_ready = 1'b1;
        @(negedge clk);
        bnd_ready = 1'b0;
        #1;
        check("R10 read after accept", int'(mem_rd), 1);
        check("R10 read address", int'(mem_addr), int'(nxt));
    endtask

    initial begin
        logic [7:0] pc, npc, op;
        void'($urandom(32'h1d5a));
        for (int i = 0; i < 256; i++) mem[i] = 8'h01;
        put_instr(8'h00, 8'h02, 8'h17, 8'h9c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 first read", int'(mem_rd), 1);
        check("R1 first address", int'(mem_addr), 0);
        check("R1 no bundle", int'(bnd_valid), 0);
        check("R1 no error", int'(illegal), 0);
        @(negedge clk);
        check("R2 no back-to-back read", int'(mem_rd), 0);

        // Random straight-line program, wrapping through memory
        pc = 8'h00;
        for (int n = 0; n < 150; n++) begin
            wait_check(pc);
            npc = 8'(pc + 8'(ref_len(mem[pc])));
            op = 8'($urandom_range(0, 39));
            put_instr(npc, op, 8'($urandom), 8'($urandom));
            accept($urandom_range(0, 2), npc);
            pc = npc;
        end

        // Redirect two cycles into a fetch, onto a 3-byte instruction at 0xFE
        put_instr(8'hFE, 8'h02, 8'h35, 8'hC7);
        @(negedge clk);
        redir_valid = 1'b1;
        redir_addr = 8'hFE;
        #1;
        check("R12 no read during redirect", int'(mem_rd), 0);
        @(negedge clk);
        redir_valid = 1'b0;
        #1;
        check("R12 read at target", int'(mem_addr), 8'hFE);
        check("R12 read strobe", int'(mem_rd), 1);
        wait_check(8'hFE);
        check("R9 wrap next", int'(bnd_next_pc), 8'h01);
        put_instr(8'h01, 8'h05, 8'hA3, 8'h00);
        accept(0, 8'h01);

        // Redirect after the opcode while the operand read is in flight
        put_instr(8'h50, 8'h1B, 8'h0E, 8'h44);
        repeat (3) @(negedge clk);
        redir_valid = 1'b1;
        redir_addr = 8'h50;
        @(negedge clk);
        redir_valid = 1'b0;
        wait_check(8'h50);

        // Redirect and handshake in the same cycle: bundle must be dropped
        put_instr(8'h60, 8'h16, 8'hD2, 8'h00);
        bnd_ready = 1'b1;
        redir_valid = 1'b1;
        redir_addr = 8'h60;
        #1;
        check("R12 valid masked", int'(bnd_valid), 0);
        @(negedge clk);
        bnd_ready = 1'b0;
        redir_valid = 1'b0;
        wait_check(8'h60);
        put_instr(8'h62, 8'h27, 8'h5B, 8'h00);
        accept(1, 8'h62);
        wait_check(8'h62);

        // Illegal opcode at the table boundary
        put_instr(8'h90, 8'h28, 8'h00, 8'h00);
        redir_valid = 1'b1;
        redir_addr = 8'h90;
        @(negedge clk);
        redir_valid = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 illegal raised", int'(illegal), 1);
        check("R11 no bundle", int'(bnd_valid), 0);
        check("R11 no read", int'(mem_rd), 0);
        redir_valid = 1'b1;
        redir_addr = 8'h00;
        @(negedge clk);
        redir_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R11 redirect ignored", int'(mem_rd), 0);
        end
        check("R11 sticky", int'(illegal), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 error cleared", int'(illegal), 0);
        check("R1 read restarts", int'(mem_rd && mem_addr == 8'h00), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule